// File: doc/BRIEF.md
# Interrupt Level Priority Resolver

This block merges sixteen level-sensitive external interrupt request lines with the contents of a software-interrupt register. From the merged set it picks one pending interrupt trap type for the processor core. Each cycle it reads the trap index that the core currently holds pending. If an external-interrupt trap may replace that index, the block proposes a new one. It also pulses a strobe when the hard-interrupt request must be raised or withdrawn.

A rising edge on any request line also pulses a wake-up output, which the core uses to leave its halted state. All outputs are registered. Each output reflects the inputs sampled at the previous clock edge, so the core normally feeds `newIndex` back into `curIndex`.

Top module: `irq_level_resolver`

## Requirements
- R1: While `rstN` is low, `newIndex` is 0 and `irqAssert`, `irqDeassert` and `haltClear` are all low.
- R2: The request vector is formed as follows. External line k and software-interrupt bit k (for k from 1 to 15) both request level k. Software-interrupt bit 0 is the timer flag, and it requests level 14.
- R3: When several levels request at once, the highest one wins. The proposed index is 0x40 ORed with the winning level, in the low 4 bits.
- R4: A level is taken only when `curIndex` is 0, or when `curIndex` with its low 4 bits cleared equals 0x40. For any other `curIndex`, `newIndex` equals `curIndex` and no strobe fires.
- R5: `irqAssert` pulses only when a taken index differs from `curIndex`. When a level is taken and the index is unchanged, `newIndex` keeps its value and no strobe fires.
- R6: Suppose no request bit at all is set: no external line and no software-interrupt bit. If `curIndex` is an external-interrupt index (0x40 to 0x4F), then `newIndex` becomes 0 and `irqDeassert` pulses. If `curIndex` is any other value, it is held and no strobe fires.
- R7: Some requests map to no level from 1 to 15: external line 0, or software-interrupt bits 16 to 31. When these are the only requests, `newIndex` equals `curIndex` and neither strobe fires. This holds even when `curIndex` is an external index.
- R8: `haltClear` pulses for one cycle after any external line is sampled high, when it was sampled low at the edge before. Falling lines do not pulse it. Line 0 counts as a line here.
- R9: Every output reflects the inputs sampled at the preceding rising clock edge. There is exactly one register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| extReq | input | 16 | External level-sensitive request lines; line 0 does not select a level |
| softint | input | 32 | Software-interrupt register value; bit 0 is the timer flag |
| curIndex | input | 9 | Trap index currently pending in the core (0 = none) |
| newIndex | output | 9 | Proposed pending trap index |
| irqAssert | output | 1 | One-cycle strobe: raise the hard-interrupt request |
| irqDeassert | output | 1 | One-cycle strobe: withdraw the hard-interrupt request |
| haltClear | output | 1 | One-cycle strobe: a request line rose, so leave the halted state |

## Verification
Two things can happen in one cycle: the wake-up pulse and an arbitration strobe. The bench provokes this by raising a new, higher line in the same cycle that another line drops. It also raises a line from an idle state, and drops every line while a new one rises. A behavioural model, kept in integers, predicts `newIndex`, both request strobes and `haltClear` independently on every clock. A mismatch on any of them is reported against the requirement of the step that was running.

// File: rtl/irq_resolver_pkg.sv
package irq_resolver_pkg;

  // Decisions handed from the control to the datapath each cycle.
  typedef struct packed {
    logic takeLevel;  // load the proposed external index
    logic clearIdx;   // drop the pending external index to zero
    logic raise;      // hard-interrupt request must be (re)asserted
    logic drop;       // hard-interrupt request must be withdrawn
  } ctlStrobes_t;

endpackage

// File: rtl/irq_res_datapath.sv
module irq_res_datapath
  import irq_resolver_pkg::*;
#(
  parameter int                NUM_LINES   = 16,
  parameter int                SOFT_W      = 32,
  parameter int                IDX_W       = 9,
  parameter logic [IDX_W-1:0]  EXT_BASE    = 9'h040,
  parameter int                TIMER_LEVEL = 14
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LINES-1:0]  extReq,
  input  logic [SOFT_W-1:0]     softint,
  input  logic [IDX_W-1:0]      curIndex,
  input  ctlStrobes_t           ctl,
  output logic                  levelAny,
  output logic                  levelHit,
  output logic                  curIsZero,
  output logic                  curIsExt,
  output logic                  candDiffers,
  output logic [IDX_W-1:0]      newIndex,
  output logic                  irqAssert,
  output logic                  irqDeassert,
  output logic                  haltClear
);

  localparam int LVL_W = $clog2(NUM_LINES);
  localparam int PIL_W = (SOFT_W > NUM_LINES) ? SOFT_W : NUM_LINES;
  localparam logic [IDX_W-1:0] LVL_MASK = IDX_W'(NUM_LINES - 1);

  logic [PIL_W-1:0]     pilVec;
  logic [NUM_LINES-1:0] aboveSet;
  logic [NUM_LINES-1:0] topHot;
  logic [LVL_W-1:0]     winLevel;
  logic [IDX_W-1:0]     candIdx;
  logic [IDX_W-1:0]     nextIdx;
  logic [NUM_LINES-1:0] extPrev;

  // Merge the lines and the software bits. The timer flag moves up to its level.
  always_comb begin
    pilVec = PIL_W'(extReq)
           | PIL_W'(softint & ~SOFT_W'(1))
           | (PIL_W'(softint[0]) << TIMER_LEVEL);
  end

  // Suffix-OR chain: aboveSet[g] tells whether any level above g is set.
  assign aboveSet[NUM_LINES-1] = 1'b0;
  assign topHot[0]             = 1'b0;
  genvar g;
  generate
    for (g = NUM_LINES - 2; g >= 0; g--) begin : gAbove
      assign aboveSet[g] = aboveSet[g+1] | pilVec[g+1];
    end
    for (g = 1; g < NUM_LINES; g++) begin : gTop
      assign topHot[g] = pilVec[g] & ~aboveSet[g];
    end
  endgenerate

  always_comb begin
    winLevel = '0;
    for (int i = 1; i < NUM_LINES; i++) begin
      if (topHot[i]) winLevel = winLevel | LVL_W'(i);
    end
  end

  assign levelAny    = |pilVec;
  assign levelHit    = |pilVec[NUM_LINES-1:1];
  assign candIdx     = EXT_BASE | IDX_W'(winLevel);
  assign curIsZero   = (curIndex == '0);
  assign curIsExt    = ((curIndex & ~LVL_MASK) == EXT_BASE);
  assign candDiffers = (candIdx != curIndex);

  always_comb begin
    if (ctl.clearIdx)       nextIdx = '0;
    else if (ctl.takeLevel) nextIdx = candIdx;
    else                    nextIdx = curIndex;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      newIndex    <= '0;
      irqAssert   <= 1'b0;
      irqDeassert <= 1'b0;
      haltClear   <= 1'b0;
      extPrev     <= '0;
    end else begin
      newIndex    <= nextIdx;
      irqAssert   <= ctl.raise;
      irqDeassert <= ctl.drop;
      haltClear   <= |(extReq & ~extPrev);
      extPrev     <= extReq;
    end
  end

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(irqAssert && irqDeassert));

  // R3
  raise_idx_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqAssert |-> (newIndex[IDX_W-1:LVL_W] == EXT_BASE[IDX_W-1:LVL_W])
                  && (newIndex[LVL_W-1:0] != '0));

  // R5
  raise_new_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqAssert |-> (newIndex != $past(curIndex)));

  // R6
  drop_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqDeassert |-> (newIndex == '0) && ($past(curIndex) != '0));

  // R8
  halt_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    haltClear |-> ($past(extReq) != '0));

endmodule

// File: rtl/irq_res_control.sv
module irq_res_control
  import irq_resolver_pkg::*;
(
  input  logic        levelAny,
  input  logic        levelHit,
  input  logic        curIsZero,
  input  logic        curIsExt,
  input  logic        candDiffers,
  output ctlStrobes_t ctl
);

  logic mayTake;

  // A pending non-external trap blocks arbitration.
  assign mayTake = curIsZero || curIsExt;

  always_comb begin
    ctl           = '0;
    if (levelAny && mayTake) begin
      // Requests that map to no level leave the index alone.
      ctl.takeLevel = levelHit;
      ctl.raise     = levelHit && candDiffers;
    end else if (!levelAny && curIsExt) begin
      ctl.clearIdx  = 1'b1;
      ctl.drop      = 1'b1;
    end
  end

endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver
  import irq_resolver_pkg::*;
#(
  parameter int                NUM_LINES   = 16,
  parameter int                SOFT_W      = 32,
  parameter int                IDX_W       = 9,
  parameter logic [IDX_W-1:0]  EXT_BASE    = 9'h040,
  parameter int                TIMER_LEVEL = 14
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LINES-1:0]  extReq,
  input  logic [SOFT_W-1:0]     softint,
  input  logic [IDX_W-1:0]      curIndex,
  output logic [IDX_W-1:0]      newIndex,
  output logic                  irqAssert,
  output logic                  irqDeassert,
  output logic                  haltClear
);

  ctlStrobes_t ctl;
  logic levelAny, levelHit, curIsZero, curIsExt, candDiffers;

  irq_res_datapath #(
    .NUM_LINES(NUM_LINES), .SOFT_W(SOFT_W), .IDX_W(IDX_W),
    .EXT_BASE(EXT_BASE), .TIMER_LEVEL(TIMER_LEVEL)
  ) u_dp (
    .clk(clk), .rstN(rstN), .extReq(extReq), .softint(softint),
    .curIndex(curIndex), .ctl(ctl), .levelAny(levelAny),
    .levelHit(levelHit), .curIsZero(curIsZero), .curIsExt(curIsExt),
    .candDiffers(candDiffers), .newIndex(newIndex), .irqAssert(irqAssert),
    .irqDeassert(irqDeassert), .haltClear(haltClear)
  );

  irq_res_control u_ctl (
    .levelAny(levelAny), .levelHit(levelHit), .curIsZero(curIsZero),
    .curIsExt(curIsExt), .candDiffers(candDiffers), .ctl(ctl)
  );

endmodule

// File: tb/irq_level_resolver_tb.sv
module irq_level_resolver_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] extReq = '0;
  logic [31:0] softint = '0;
  logic [8:0]  curIndex;
  logic [8:0]  newIndex;
  logic        irqAssert, irqDeassert, haltClear;

  logic        fbMode = 1'b1;
  logic [8:0]  forcedCur = '0;
  logic [8:0]  curFb = '0;
  logic        checkOn = 1'b0;
  logic        finished = 1'b0;
  string       tag = "R1";

  int checks = 0;
  int errors = 0;

  // Reference model state
  int unsigned expIdx = 0;
  bit          expA = 0, expD = 0, expH = 0;
  int unsigned prevExt = 0;

  always #2.5 clk = ~clk;

  assign curIndex = fbMode ? curFb : forcedCur;

  irq_level_resolver u_dut (
    .clk(clk), .rstN(rstN), .extReq(extReq), .softint(softint),
    .curIndex(curIndex), .newIndex(newIndex), .irqAssert(irqAssert),
    .irqDeassert(irqDeassert), .haltClear(haltClear)
  );

  // The feedback path stands in for the core taking the index. It changes on the falling edge.
  always @(negedge clk) curFb <= newIndex;

  // Behavioural reference (R9: one edge of latency)
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expIdx = 0; expA = 0; expD = 0; expH = 0; prevExt = 0;
    end else begin
      int unsigned pil, cur, win, ext;
      bit isExt;
      ext = 32'(extReq);
      cur = 32'(curIndex);
      pil = ext | (softint & ~32'd1) | ((softint & 32'd1) << 14);
      win = 0;
      for (int i = 15; i > 0; i--) begin
        if (((pil >> i) & 1) != 0) begin win = i; break; end
      end
      isExt = ((cur & ~32'd15) == 32'h40);
      expA = 0; expD = 0; expIdx = cur;
      if (pil != 0 && (cur == 0 || isExt)) begin
        if (win != 0) begin
          expIdx = 32'h40 | win;
          expA = (expIdx != cur);
        end
      end else if (pil == 0 && isExt) begin
        expIdx = 0;
        expD = 1;
      end
      expH = ((ext & ~prevExt) != 0);
      prevExt = ext;
    end
  end

  task automatic checkOne(string name, int unsigned act, int unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, name, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (checkOn) begin
      checkOne("newIndex", 32'(newIndex), expIdx);
      checkOne("irqAssert", 32'(irqAssert), 32'(expA));
      checkOne("irqDeassert", 32'(irqDeassert), 32'(expD));
      checkOne("haltClear", 32'(haltClear), 32'(expH));
    end
  end

  task automatic step(string t, logic [15:0] e, logic [31:0] s, int n);
    @(negedge clk);
    tag = t;
    extReq = e;
    softint = s;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    // R1: outputs held at zero during reset, with requests present
    extReq = 16'h0200;
    softint = 32'h1;
    repeat (3) @(negedge clk);
    tag = "R1";
    checkOne("newIndex", 32'(newIndex), 0);
    checkOne("irqAssert", 32'(irqAssert), 0);
    checkOne("irqDeassert", 32'(irqDeassert), 0);
    checkOne("haltClear", 32'(haltClear), 0);
    extReq = '0;
    softint = '0;
    rstN = 1'b1;
    checkOn = 1'b1;

    // R7: requests with no level from 1 to 15
    step("R7", 16'h0001, 32'h0, 4);
    step("R7", 16'h0000, 32'h0010_0000, 4);
    // R2: the timer flag selects level 14
    step("R2", 16'h0000, 32'h0000_0001, 4);
    // R7: an external index is held while only unmapped bits request
    step("R7", 16'h0001, 32'h8000_0000, 4);
    // R6: nothing requests, so the external index drops
    step("R6", 16'h0000, 32'h0, 4);
    // R3: the highest of several levels wins
    step("R3", 16'h0208, 32'h0, 4);
    step("R3", 16'h0208, 32'h0000_8000, 4);
    step("R3", 16'h0208, 32'h0, 4);
    // R5: a steady level raises no new strobe
    step("R5", 16'h0208, 32'h0, 6);
    // R8: a rising line while another falls, together with a new level
    step("R8", 16'h0800, 32'h0, 4);
    step("R8", 16'h0000, 32'h0, 3);
    step("R8", 16'h0010, 32'h0, 3);
    // R2: software bit 5 and external line 5 share a level
    step("R2", 16'h0000, 32'h0000_0020, 4);
    step("R2", 16'h0020, 32'h0000_0020, 4);
    // R4: a non-external pending trap blocks arbitration
    @(negedge clk);
    fbMode = 1'b0;
    forcedCur = 9'h005;
    step("R4", 16'h0080, 32'h0, 4);
    forcedCur = 9'h085;
    step("R4", 16'h0080, 32'h1, 4);
    // R6: with no request and a non-external index, nothing fires
    forcedCur = 9'h005;
    step("R6", 16'h0000, 32'h0, 4);
    // R4: an external index may be replaced
    forcedCur = 9'h043;
    step("R4", 16'h0080, 32'h0, 4);
    // R5: an equal index is re-taken without a strobe
    forcedCur = 9'h047;
    step("R5", 16'h0080, 32'h0, 4);
    // R9: the output follows the input one edge later
    forcedCur = 9'h000;
    step("R9", 16'h4000, 32'h0, 2);
    step("R9", 16'h0000, 32'h0, 2);
    step("R9", 16'h0002, 32'h0, 3);
    @(negedge clk);
    checkOn = 1'b0;
    finished = 1'b1;
    summary();
  end

endmodule